// File: doc/BRIEF.md
# PLL Programmable Feedback and Reference Dividers

This block holds the two programmable counters that feed a PLL phase detector. The reference divider counts crystal clock cycles and emits one pulse every Q+2 cycles, where Q is a 7-bit code. The feedback divider counts VCO clock cycles and emits one pulse every 2·(P+4)+Po cycles. P is a 10-bit code and Po is a single odd-offset bit, so both even and odd feedback ratios can be set. The phase detector compares the two pulse trains. The detector, the charge pump and the VCO lie outside this block.

Each divider counts down from its full ratio. At its terminal count it raises a pulse for one cycle of its own clock and loads the ratio that the current code selects. A code is therefore sampled only at a period boundary, and no period is ever cut short. A spread modulator can step P from period to period, and the average frequency then follows the time average of P. Both counters share one active-low synchronous reset, which each clock domain samples. The reset must be held for at least a few cycles of the slower clock.

Top module: `pll_div_pair`

## Requirements
- R1: The reference pulse repeats every Q+2 reference clock cycles, where Q is the unsigned 7-bit value on `ref_code`.
- R2: The feedback pulse repeats every 2·(P+4)+Po VCO clock cycles, where P is the unsigned 10-bit value on `fb_code` and Po is `fb_odd`.
- R3: Each output pulse is high for exactly one cycle of its own clock.
- R4: While `rst_n` is low both pulses are low. After `rst_n` is sampled high, the first pulse of each divider appears on the rising edge that is its full ratio of clock edges later, counting the first edge with reset high as edge 1.
- R5: A change of a code in the middle of a period does not alter that period. The new ratio applies from the period that begins at the next terminal count.
- R6: The boundary codes give these ratios: P=0 gives 8 or 9, P=1023 gives 2054 or 2055 (Po = 0 or 1), Q=0 gives 2 and Q=127 gives 129.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Crystal reference clock |
| vco_clk | input | 1 | VCO clock |
| rst_n | input | 1 | Synchronous reset, active low, sampled in both domains |
| ref_code | input | 7 | Reference code Q, sampled in the ref_clk domain |
| fb_code | input | 10 | Feedback code P, sampled in the vco_clk domain |
| fb_odd | input | 1 | Odd offset bit Po for the feedback ratio |
| ref_pulse | output | 1 | One-cycle reference pulse per reference period |
| fb_pulse | output | 1 | One-cycle feedback pulse per feedback period |

## Verification
The feedback divider is measured with P at 0, 1023 and a mid-range value, each with Po at both values. These tests separate an error in the doubling from an error in the offset or in the odd bit. The reference divider is measured at Q=0, Q=127 and a middle value, which exposes an off-by-one error in the +2 offset. A code changed part of the way through a period shows whether a load happens only at the terminal count, because the interrupted period must keep the old spacing and only the next period takes the new one. Separate reset releases in each clock domain fix the phase of the first pulse.

// File: rtl/pll_div_pkg.sv
// Package: widths, offsets and derived ratio widths shared by the divider pair.
// Assumes codes are unsigned binary.
package pll_div_pkg;
    localparam int FB_CODE_W  = 10;
    localparam int REF_CODE_W = 7;
    localparam int FB_OFS     = 4;
    localparam int REF_OFS    = 2;
    // Widest ratio each divider can reach, plus one, sets the counter width.
    localparam int FB_MAX     = 2 * ((1 << FB_CODE_W) - 1 + FB_OFS) + 1;
    localparam int REF_MAX    = (1 << REF_CODE_W) - 1 + REF_OFS;
    localparam int FB_RW      = $clog2(FB_MAX + 1);
    localparam int REF_RW     = $clog2(REF_MAX + 1);
endpackage

// File: rtl/fb_ratio_gen.sv
// Feedback ratio: maps the code and odd bit to 2*(code+OFS)+odd.
// Assumes RW is wide enough that the top value does not wrap.
module fb_ratio_gen #(
    parameter int CODE_W = 10,
    parameter int OFS    = 4,
    parameter int RW     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              odd,
    output logic [RW-1:0]     ratio
);
    localparam int HW = RW - 1;
    logic [HW-1:0] half;

    // Forms the halved ratio and appends the odd bit as the LSB.
    always_comb begin
        half  = HW'(code) + HW'(OFS);
        ratio = {half, odd};
    end

    AST_FB_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        ratio[0] == odd);                                   // R2
    AST_FB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ratio >= RW'(2 * OFS));                             // R6
endmodule

// File: rtl/ref_ratio_gen.sv
// Reference ratio: maps the code to code+OFS.
// Assumes RW holds the largest code plus the offset.
module ref_ratio_gen #(
    parameter int CODE_W = 7,
    parameter int OFS    = 2,
    parameter int RW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic [RW-1:0]     ratio
);
    // Adds the fixed offset to the zero-extended code.
    always_comb ratio = RW'(code) + RW'(OFS);

    AST_REF_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio >= RW'(OFS)) && (ratio <= RW'((1 << CODE_W) - 1 + OFS)));  // R1
endmodule

// File: rtl/div_counter.sv
// Down-counter divider: emits a one-cycle pulse per ratio_in cycles and
// samples ratio_in only at the terminal count.
// Assumes ratio_in >= 2 at every load.
module div_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] ratio_in,
    output logic          pulse
);
    logic [CW-1:0] cnt;
    logic          at_tc;

    // Terminal count reached when one cycle of the period remains.
    always_comb at_tc = (cnt == CW'(1));

    // Counts down, reloads the full ratio and pulses at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= ratio_in;
            pulse <= 1'b0;
        end else if (at_tc) begin
            cnt   <= ratio_in;
            pulse <= 1'b1;
        end else begin
            cnt   <= cnt - CW'(1);
            pulse <= 1'b0;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);                                  // R3
    AST_RELOAD_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> cnt == $past(ratio_in));                  // R5
    AST_DECR_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !pulse) |-> cnt == $past(cnt) - CW'(1));  // R5
    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '0);                                         // R4
endmodule

// File: rtl/pll_div_pair.sv
// Top: reference and feedback dividers in front of a PLL phase detector.
// Assumes rst_n is held low for several cycles of the slower clock and that
// each code is driven from its own divider's clock domain.
module pll_div_pair
    import pll_div_pkg::*;
(
    input  logic                  ref_clk,
    input  logic                  vco_clk,
    input  logic                  rst_n,
    input  logic [REF_CODE_W-1:0] ref_code,
    input  logic [FB_CODE_W-1:0]  fb_code,
    input  logic                  fb_odd,
    output logic                  ref_pulse,
    output logic                  fb_pulse
);
    logic [REF_RW-1:0] ref_ratio;
    logic [FB_RW-1:0]  fb_ratio;

    ref_ratio_gen #(.CODE_W(REF_CODE_W), .OFS(REF_OFS), .RW(REF_RW)) u_ref_ratio (
        .clk(ref_clk), .rst_n(rst_n), .code(ref_code), .ratio(ref_ratio));

    fb_ratio_gen #(.CODE_W(FB_CODE_W), .OFS(FB_OFS), .RW(FB_RW)) u_fb_ratio (
        .clk(vco_clk), .rst_n(rst_n), .code(fb_code), .odd(fb_odd), .ratio(fb_ratio));

    div_counter #(.CW(REF_RW)) u_ref_div (
        .clk(ref_clk), .rst_n(rst_n), .ratio_in(ref_ratio), .pulse(ref_pulse));

    div_counter #(.CW(FB_RW)) u_fb_div (
        .clk(vco_clk), .rst_n(rst_n), .ratio_in(fb_ratio), .pulse(fb_pulse));
endmodule

// File: tb/pll_div_pair_bench.sv
`timescale 1ns/10ps
module pll_div_pair_bench;
    logic       ref_clk = 1'b0;
    logic       vco_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [6:0] ref_code = 7'd0;
    logic [9:0] fb_code  = 10'd0;
    logic       fb_odd   = 1'b0;
    logic       ref_pulse, fb_pulse;
    int checks = 0;
    int errors = 0;

    pll_div_pair u_pll_div_pair (
        .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n),
        .ref_code(ref_code), .fb_code(fb_code), .fb_odd(fb_odd),
        .ref_pulse(ref_pulse), .fb_pulse(fb_pulse));

    always #2 vco_clk = ~vco_clk;                 // 250 MHz
    initial begin
        #0.3;
        forever #5.25 ref_clk = ~ref_clk;         // edges never on integer ns
    end

    function automatic int fb_exp(int p, int po);
        return 2 * (p + 4) + po;
    endfunction

    task automatic check(string req, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Waits for a feedback pulse that begins after the call.
    task automatic sync_fb();
        do @(negedge vco_clk); while (!fb_pulse);
    endtask
    task automatic sync_ref();
        do @(negedge ref_clk); while (!ref_pulse);
    endtask

    // Counts VCO cycles to the next pulse and checks width (R3).
    task automatic span_fb(output int n);
        n = 0;
        do begin @(negedge vco_clk); n++;
            if (n == 1) check("R3 fb width", int'(fb_pulse), 0);
        end while (!fb_pulse && n < 5000);
    endtask
    task automatic span_ref(output int n);
        n = 0;
        do begin @(negedge ref_clk); n++;
            if (n == 1) check("R3 ref width", int'(ref_pulse), 0);
        end while (!ref_pulse && n < 500);
    endtask

    task automatic t_reset_fb(int p, int po);
        int n;
        @(negedge vco_clk); rst_n = 1'b0; fb_code = 10'(p); fb_odd = 1'(po);
        repeat (6) @(negedge vco_clk);
        check("R4 fb quiet in reset", int'(fb_pulse), 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge vco_clk); n++; end while (!fb_pulse && n < 5000);
        check("R4 fb first pulse", n, fb_exp(p, po));
    endtask

    task automatic t_reset_ref(int q);
        int n;
        @(negedge ref_clk); rst_n = 1'b0; ref_code = 7'(q);
        repeat (4) @(negedge ref_clk);
        check("R4 ref quiet in reset", int'(ref_pulse), 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge ref_clk); n++; end while (!ref_pulse && n < 500);
        check("R4 ref first pulse", n, q + 2);
    endtask

    task automatic t_fb_ratio(int p, int po, string req);
        int n;
        @(negedge vco_clk); fb_code = 10'(p); fb_odd = 1'(po);
        sync_fb();
        span_fb(n);
        check(req, n, fb_exp(p, po));
    endtask

    task automatic t_ref_ratio(int q, string req);
        int n;
        @(negedge ref_clk); ref_code = 7'(q);
        sync_ref();
        span_ref(n);
        check(req, n, q + 2);
    endtask

    // Code change three cycles into a period: old span, then new span (R5).
    task automatic t_fb_midchange(int pa, int pb);
        int n;
        @(negedge vco_clk); fb_code = 10'(pa); fb_odd = 1'b1;
        sync_fb();
        repeat (3) @(negedge vco_clk);
        fb_code = 10'(pb); fb_odd = 1'b0;
        n = 3;
        do begin @(negedge vco_clk); n++; end while (!fb_pulse && n < 5000);
        check("R5 fb period kept", n, fb_exp(pa, 1));
        span_fb(n);
        check("R5 fb new period", n, fb_exp(pb, 0));
    endtask

    task automatic t_ref_midchange(int qa, int qb);
        int n;
        @(negedge ref_clk); ref_code = 7'(qa);
        sync_ref();
        repeat (2) @(negedge ref_clk);
        ref_code = 7'(qb);
        n = 2;
        do begin @(negedge ref_clk); n++; end while (!ref_pulse && n < 500);
        check("R5 ref period kept", n, qa + 2);
        span_ref(n);
        check("R5 ref new period", n, qb + 2);
    endtask

    initial begin
        repeat (150000) @(posedge vco_clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_fb(5, 1);
        t_reset_ref(9);
        t_fb_ratio(0, 0, "R6 P=0 Po=0");
        t_fb_ratio(0, 1, "R6 P=0 Po=1");
        t_fb_ratio(1023, 0, "R6 P=1023 Po=0");
        t_fb_ratio(1023, 1, "R6 P=1023 Po=1");
        t_fb_ratio(37, 0, "R2 P=37 Po=0");
        t_fb_ratio(37, 1, "R2 P=37 Po=1");
        t_ref_ratio(0, "R6 Q=0");
        t_ref_ratio(127, "R6 Q=127");
        t_ref_ratio(50, "R1 Q=50");
        t_fb_midchange(100, 2);
        t_ref_midchange(40, 3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule